// File: doc/BRIEF.md
# Relocatable Row Configuration Store

This block holds the configuration memory of a one-dimensional, row-organised, partially reconfigurable array. A host never touches individual memory columns. It fills a staging register that is exactly one row wide, one word at a time and in any order. It then commits that register to a whole memory row in a single cycle. It can also fetch a whole row back into the staging register in one cycle and read it out word by word.

Every row access is translated before it reaches the row decoder. The physical row is the logical row plus the contents of one of several offset registers, picked per command. A configuration can therefore be placed anywhere in the array without its data being edited. To compact the array, the host sets a source offset and a destination offset and issues one move command. The block then copies N consecutive rows through the staging register, one read cycle and one write cycle per row, and orders the copies so that overlapping source and destination ranges do not corrupt each other.

Commands use a valid/ready handshake. A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. Any row access whose translated range runs past the last physical row is refused, and the refusal is flagged on `err`.

Top module: `cfgmem_reloc`

## Requirements
- R1: After reset, the staging words, every memory row and every offset register are zero; `busy`, `err` and `rsp_valid` are low and `cmd_ready` is high.
- R2: Opcode 0 (load word) writes `cmd_data` into staging word `cmd_word_addr` and leaves the other staging words as they were. Words may be loaded in any order.
- R3: Opcode 1 (commit) writes the whole staging register into physical row `cmd_row + offset[cmd_off_sel]` in the accepting cycle. The staging register is left unchanged.
- R4: Opcode 2 (fetch) copies physical row `cmd_row + offset[cmd_off_sel]` into the staging register in the accepting cycle.
- R5: Opcode 3 (read word) returns staging word `cmd_word_addr` on `rsp_data`, with `rsp_valid` high for exactly the one cycle after acceptance.
- R6: Opcode 4 (set offset) stores `cmd_row` into offset register `cmd_off_sel`. No other command changes any offset register.
- R7: When a commit or fetch would reach a physical row at or beyond `NUM_ROWS`, it is refused. `err` pulses high for the one cycle after acceptance, and neither memory nor staging changes.
- R8: Opcode 5 (move) copies `cmd_count` rows. Source row i is `cmd_row + offset[cmd_off_sel] + i` and destination row i is `cmd_row + offset[cmd_dst_sel] + i`. Row contents arrive unchanged. `busy` is high for exactly 2·`cmd_count` cycles starting the cycle after acceptance, and `cmd_ready` is low throughout.
- R9: When the source and destination ranges of a move overlap, the result equals a simultaneous copy. Rows are copied in ascending order when moving toward lower rows and in descending order otherwise. Afterwards the staging register holds the last row copied.
- R10: A move with `cmd_count` of zero, or with either range extending past the last row, is refused. `err` pulses, `busy` stays low and no row changes.
- R11: Opcodes 6 and 7 are ignored. They change no state and raise neither `err` nor `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command (low during a move) |
| cmd_op | input | 3 | Opcode: 0 load, 1 commit, 2 fetch, 3 read, 4 set offset, 5 move |
| cmd_row | input | $clog2(NUM_ROWS) | Logical row; offset value for set offset |
| cmd_word_addr | input | $clog2(WORDS_PER_ROW) | Staging word index |
| cmd_off_sel | input | $clog2(NUM_OFFS) | Offset register for access or move source |
| cmd_dst_sel | input | $clog2(NUM_OFFS) | Offset register for move destination |
| cmd_count | input | $clog2(NUM_ROWS)+1 | Number of rows to move |
| cmd_data | input | WORD_W | Word to load |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | WORD_W | Read data |
| busy | output | 1 | Move in progress |
| err | output | 1 | Previous command refused |

## Verification
The embedded assertions check, on every cycle, that a committed row lands exactly as staged. They also check that a read and a write never share a cycle, that each move read is followed by its write, that a move always ends on a write, that a refusal coincides with no memory access, and that offset registers hold except under a set-offset command. Several properties cannot be seen from any single cycle, so only the bench scenarios can show them. These are the correct relocation arithmetic, overlap-safe ordering for both move directions, the exact busy length, and that refused and unknown commands leave memory and staging intact. The bench shows them by comparing full row read-back against a reference model after random command mixes and directed moves.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_COMMIT = 3'd1,
        OP_FETCH  = 3'd2,
        OP_READ   = 3'd3,
        OP_SETOFF = 3'd4,
        OP_MOVE   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RD   = 2'd1,
        SQ_WR   = 2'd2
    } sq_e;
endpackage

// File: rtl/cfgmem_xlate.sv
module cfgmem_xlate #(
    parameter int NUM_ROWS = 16,
    parameter int NUM_OFFS = 4,
    parameter int RAW      = $clog2(NUM_ROWS),
    parameter int SW       = $clog2(NUM_OFFS)
) (
    input  logic [NUM_OFFS-1:0][RAW-1:0] offs,
    input  logic [SW-1:0]                sel,
    input  logic [RAW-1:0]               row,
    input  logic [RAW:0]                 span,
    output logic [RAW-1:0]               phys,
    output logic                         oob
);
    logic [RAW+1:0] base;
    logic [RAW+1:0] limit;

    always_comb begin
        base  = {2'b00, row} + {2'b00, offs[sel]};
        limit = base + {1'b0, span};
        phys  = base[RAW-1:0];
        oob   = (limit > (RAW+2)'(NUM_ROWS)) | (base >= (RAW+2)'(NUM_ROWS));
    end
endmodule

// File: rtl/cfgmem_move_seq.sv
module cfgmem_move_seq
    import cfgmem_pkg::*;
#(
    parameter int NUM_ROWS = 16,
    parameter int RAW      = $clog2(NUM_ROWS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [RAW-1:0] src_base,
    input  logic [RAW-1:0] dst_base,
    input  logic [RAW:0]   count,
    output logic           busy,
    output logic           rd,
    output logic           wr,
    output logic [RAW-1:0] rd_row,
    output logic [RAW-1:0] wr_row
);
    typedef struct packed {
        sq_e            st;
        logic           asc;
        logic [RAW-1:0] src;
        logic [RAW-1:0] dst;
        logic [RAW:0]   cnt;
        logic [RAW:0]   idx;
    } seq_t;

    seq_t q, d;
    logic [RAW-1:0] step;

    always_comb begin
        d      = q;
        step   = q.asc ? q.idx[RAW-1:0] : RAW'(q.cnt - q.idx - 1'b1);
        rd_row = q.src + step;
        wr_row = q.dst + step;
        rd     = (q.st == SQ_RD);
        wr     = (q.st == SQ_WR);
        busy   = (q.st != SQ_IDLE);
        case (q.st)
            SQ_IDLE: if (start) begin
                d.st  = SQ_RD;
                d.asc = (dst_base < src_base);
                d.src = src_base;
                d.dst = dst_base;
                d.cnt = count;
                d.idx = '0;
            end
            SQ_RD: d.st = SQ_WR;
            SQ_WR: begin
                if (q.idx == q.cnt - 1'b1) begin
                    d.st = SQ_IDLE;
                end else begin
                    d.st  = SQ_RD;
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SQ_IDLE, default: '0};
        else        q <= d;
    end

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> wr); // R8
    AST_MOVE_ENDS_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr)); // R9
endmodule

// File: rtl/cfgmem_row_store.sv
module cfgmem_row_store #(
    parameter int WORD_W        = 8,
    parameter int WORDS_PER_ROW = 4,
    parameter int NUM_ROWS      = 16,
    parameter int RAW           = $clog2(NUM_ROWS),
    parameter int WAW           = $clog2(WORDS_PER_ROW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_we,
    input  logic [WAW-1:0]    word_addr,
    input  logic [WORD_W-1:0] word_data,
    input  logic              row_rd,
    input  logic [RAW-1:0]    rd_row,
    input  logic              row_wr,
    input  logic [RAW-1:0]    wr_row,
    output logic [WORD_W-1:0] rd_word
);
    typedef logic [WORDS_PER_ROW-1:0][WORD_W-1:0] row_t;

    typedef struct packed {
        row_t                   stage;
        logic [NUM_ROWS-1:0][WORDS_PER_ROW*WORD_W-1:0] mem;
    } store_t;

    store_t q, d;

    always_comb begin
        d = q;
        if (word_we) d.stage[word_addr] = word_data;
        if (row_rd)  d.stage = q.mem[rd_row];
        if (row_wr)  d.mem[wr_row] = q.stage;
        rd_word = q.stage[word_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_NO_RDWR_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_rd && row_wr)); // R4
    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        row_wr |=> (q.mem[$past(wr_row)] == $past(q.stage))); // R3
endmodule

// File: rtl/cfgmem_reloc.sv
module cfgmem_reloc
    import cfgmem_pkg::*;
#(
    parameter int WORD_W        = 8,
    parameter int WORDS_PER_ROW = 4,
    parameter int NUM_ROWS      = 16,
    parameter int NUM_OFFS      = 4,
    parameter int RAW           = $clog2(NUM_ROWS),
    parameter int WAW           = $clog2(WORDS_PER_ROW),
    parameter int SW            = $clog2(NUM_OFFS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [RAW-1:0]    cmd_row,
    input  logic [WAW-1:0]    cmd_word_addr,
    input  logic [SW-1:0]     cmd_off_sel,
    input  logic [SW-1:0]     cmd_dst_sel,
    input  logic [RAW:0]      cmd_count,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              busy,
    output logic              err
);
    typedef struct packed {
        logic [NUM_OFFS-1:0][RAW-1:0] offs;
        logic                         err;
        logic                         rsp_v;
        logic [WORD_W-1:0]            rsp_d;
    } top_t;

    top_t q, d;

    logic              acc, is_move;
    logic [RAW:0]      span;
    logic [RAW-1:0]    src_phys, dst_phys;
    logic              src_oob, dst_oob;
    logic              seq_busy, seq_rd, seq_wr, seq_start;
    logic [RAW-1:0]    seq_rd_row, seq_wr_row;
    logic              ld_we, c_rd, c_wr, row_rd, row_wr;
    logic [RAW-1:0]    rd_row, wr_row;
    logic [WORD_W-1:0] rd_word;

    assign is_move = (cmd_op == OP_MOVE);
    assign span    = is_move ? cmd_count : (RAW+1)'(1);

    cfgmem_xlate #(.NUM_ROWS(NUM_ROWS), .NUM_OFFS(NUM_OFFS)) u_src (
        .offs(q.offs), .sel(cmd_off_sel), .row(cmd_row), .span(span),
        .phys(src_phys), .oob(src_oob));

    cfgmem_xlate #(.NUM_ROWS(NUM_ROWS), .NUM_OFFS(NUM_OFFS)) u_dst (
        .offs(q.offs), .sel(cmd_dst_sel), .row(cmd_row), .span(span),
        .phys(dst_phys), .oob(dst_oob));

    cfgmem_move_seq #(.NUM_ROWS(NUM_ROWS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(seq_start),
        .src_base(src_phys), .dst_base(dst_phys), .count(cmd_count),
        .busy(seq_busy), .rd(seq_rd), .wr(seq_wr),
        .rd_row(seq_rd_row), .wr_row(seq_wr_row));

    always_comb begin
        d         = q;
        d.err     = 1'b0;
        d.rsp_v   = 1'b0;
        acc       = cmd_valid && !seq_busy;
        ld_we     = 1'b0;
        c_rd      = 1'b0;
        c_wr      = 1'b0;
        seq_start = 1'b0;
        if (acc) begin
            case (cmd_op)
                OP_LOAD:   ld_we = 1'b1;
                OP_COMMIT: if (src_oob) d.err = 1'b1; else c_wr = 1'b1;
                OP_FETCH:  if (src_oob) d.err = 1'b1; else c_rd = 1'b1;
                OP_READ: begin
                    d.rsp_v = 1'b1;
                    d.rsp_d = rd_word;
                end
                OP_SETOFF: d.offs[cmd_off_sel] = cmd_row;
                OP_MOVE: begin
                    if (cmd_count == '0 || src_oob || dst_oob) d.err = 1'b1;
                    else seq_start = 1'b1;
                end
                default: ;
            endcase
        end
        row_rd = c_rd | seq_rd;
        row_wr = c_wr | seq_wr;
        rd_row = seq_busy ? seq_rd_row : src_phys;
        wr_row = seq_busy ? seq_wr_row : src_phys;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    cfgmem_row_store #(
        .WORD_W(WORD_W), .WORDS_PER_ROW(WORDS_PER_ROW), .NUM_ROWS(NUM_ROWS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .word_we(ld_we), .word_addr(cmd_word_addr), .word_data(cmd_data),
        .row_rd(row_rd), .rd_row(rd_row), .row_wr(row_wr), .wr_row(wr_row),
        .rd_word(rd_word));

    assign cmd_ready = !seq_busy;
    assign busy      = seq_busy;
    assign err       = q.err;
    assign rsp_valid = q.rsp_v;
    assign rsp_data  = q.rsp_d;

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        d.err |-> !(row_rd || row_wr || seq_start)); // R7
    AST_OFFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && cmd_op == OP_SETOFF) |=> $stable(q.offs)); // R6
endmodule

// File: tb/tb_cfgmem_reloc.sv
module tb_cfgmem_reloc;
    localparam int CLK_PERIOD = 10;
    localparam int WW = 8, WPR = 4, NR = 16, NO = 4;
    localparam int RAW = 4, WAW = 2, SW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [RAW-1:0] cmd_row = '0;
    logic [WAW-1:0] cmd_word_addr = '0;
    logic [SW-1:0] cmd_off_sel = '0, cmd_dst_sel = '0;
    logic [RAW:0] cmd_count = '0;
    logic [WW-1:0] cmd_data = '0;
    logic rsp_valid, busy, err;
    logic [WW-1:0] rsp_data;

    int nchk = 0, nerr = 0;
    bit done = 0;

    logic [WPR*WW-1:0] mmem [NR];
    logic [WPR*WW-1:0] mstage;
    int moff [NO];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgmem_reloc dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit oob(int row, int sel, int n);
        return (row + moff[sel] + n) > NR;
    endfunction

    task automatic send(int op, int row, int wa, int sel, int dsel, int data, int cnt);
        cmd_op = 3'(op); cmd_row = RAW'(row); cmd_word_addr = WAW'(wa);
        cmd_off_sel = SW'(sel); cmd_dst_sel = SW'(dsel);
        cmd_data = WW'(data); cmd_count = (RAW+1)'(cnt); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ld(int wa, int data);
        send(0, 0, wa, 0, 0, data, 0);
        mstage[wa*WW +: WW] = WW'(data);
        chk("R2 load no err", {31'b0, err}, 0);
    endtask

    task automatic commit(int row, int sel);
        bit e = oob(row, sel, 1);
        send(1, row, 0, sel, 0, 0, 0);
        if (!e) mmem[row + moff[sel]] = mstage;
        chk(e ? "R7 commit refused" : "R3 commit", {31'b0, err}, {31'b0, e});
    endtask

    task automatic fetch(int row, int sel);
        bit e = oob(row, sel, 1);
        send(2, row, 0, sel, 0, 0, 0);
        if (!e) mstage = mmem[row + moff[sel]];
        chk(e ? "R7 fetch refused" : "R4 fetch", {31'b0, err}, {31'b0, e});
    endtask

    task automatic rdw(int wa, string req);
        send(3, 0, wa, 0, 0, 0, 0);
        chk({req, " rsp_valid"}, {31'b0, rsp_valid}, 1);
        chk({req, " R5 data"}, {24'b0, rsp_data}, {24'b0, mstage[wa*WW +: WW]});
        @(negedge clk);
        chk("R5 rsp_valid one cycle", {31'b0, rsp_valid}, 0);
    endtask

    task automatic setoff(int sel, int val);
        send(4, val, 0, sel, 0, 0, 0);
        moff[sel] = val;
    endtask

    task automatic move(int row, int s, int d, int n);
        logic [WPR*WW-1:0] tmp [NR];
        bit e = (n == 0) || oob(row, s, n) || oob(row, d, n);
        int sb = row + moff[s], db = row + moff[d], bcnt = 0;
        send(5, row, 0, s, d, 0, n);
        chk(e ? "R10 move refused" : "R8 move err", {31'b0, err}, {31'b0, e});
        while (busy && bcnt < 1000) begin
            chk("R8 ready low while busy", {31'b0, cmd_ready}, 0);
            bcnt++;
            @(negedge clk);
        end
        chk(e ? "R10 no busy" : "R8 busy length", bcnt, e ? 0 : 2*n);
        if (!e) begin
            for (int i = 0; i < NR; i++) tmp[i] = mmem[i];
            for (int i = 0; i < n; i++) mmem[db + i] = tmp[sb + i];
            mstage = (db < sb) ? tmp[sb + n - 1] : tmp[sb];
        end
    endtask

    task automatic verify_all(string req);
        for (int r = 0; r < NR; r++) begin
            fetch(r, 0);
            for (int w = 0; w < WPR; w++) rdw(w, req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NR; i++) mmem[i] = '0;
        for (int i = 0; i < NO; i++) moff[i] = 0;
        mstage = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 err", {31'b0, err}, 0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 0);
        chk("R1 cmd_ready", {31'b0, cmd_ready}, 1);
        verify_all("R1 memory zero");
        // R2 out-of-order loads
        ld(3, 8'hD3); ld(0, 8'hA0); ld(2, 8'hC2); ld(1, 8'hB1); ld(2, 8'h5C);
        for (int w = 0; w < WPR; w++) rdw(w, "R2");
        commit(NR-1, 0);
        // R6 offsets and R7 refusal at the top row
        setoff(1, 3);
        commit(12, 1);
        commit(13, 1);
        fetch(13, 1);
        // R11 unknown opcodes
        send(6, 2, 1, 0, 0, 8'hFF, 3);
        chk("R11 op6 no err", {31'b0, err}, 0);
        chk("R11 op6 no rsp", {31'b0, rsp_valid}, 0);
        send(7, 2, 1, 0, 0, 8'hFF, 3);
        chk("R11 op7 no busy", {31'b0, busy}, 0);
        for (int w = 0; w < WPR; w++) rdw(w, "R11 stage intact");
        // random mix
        for (int it = 0; it < 400; it++) begin
            int k = int'($urandom % 5);
            int rw = int'($urandom % NR);
            int sl = int'($urandom % NO);
            int wa = int'($urandom % WPR);
            case (k)
                0: ld(wa, int'($urandom % 256));
                1: commit(rw, sl);
                2: fetch(rw, sl);
                3: rdw(wa, "R5 random");
                default: setoff(1 + int'($urandom % 3), int'($urandom % NR));
            endcase
        end
        verify_all("R3 R4 random");
        // R9 overlapping moves, both directions
        setoff(1, 2); setoff(2, 5);
        move(0, 1, 2, 6);
        verify_all("R9 move up");
        move(1, 2, 1, 7);
        verify_all("R9 move down");
        move(0, 0, 3, 4);
        verify_all("R8 disjoint move");
        // R10 refused moves
        move(0, 1, 2, 0);
        setoff(3, 12);
        move(0, 1, 3, 6);
        move(10, 2, 1, 3);
        verify_all("R10 memory intact");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule